// File: doc/BRIEF.md
# Flash Status Polling Generator

This block forms the read data that a parallel flash device presents while its command sequencer sits in one of several modes. In plain read mode it passes array data through. In identification mode it decodes a small word index into device ID words. In query mode it returns bytes of a parameter table. While an embedded program or erase algorithm runs, it returns a polling status byte instead of array data.

The status byte holds four live flags. The data-polling flag (bit 7) shows the complement of the bit being programmed, or a 0 while an erase runs. The toggle flag (bit 6) flips on every status read. The erase-toggle flag (bit 2) flips on every status read of an erase. The erase-started flag (bit 3) shows whether the sector-erase command window has closed. All other bits read 0. The sequencer and the timers sit outside. They tell this block, with one-cycle event pulses and level flags, when an operation starts, begins erasing, completes, is suspended or resumes. Array storage, the ID words and the table bytes also come from outside.

A read strobe captures the selected word into a register, so the data appears one cycle later. The flag toggles that the read causes take effect in that same capture.

Top module: `flash_status_poll`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 0 and all four status flags are 0. A first program-mode read therefore returns 0x40.
- R2: `rd_valid` is 1 exactly in the cycle after a cycle with `rd_stb` high. `rd_data` changes only in such a cycle and otherwise holds its value.
- R3: An `ev_prog` pulse sets bit 7 of the status to the complement of `prog_d7`.
- R4: An `ev_erase_start` or `ev_resume` pulse sets bit 7 to 0. An `ev_done` pulse inverts bit 7. For simultaneous pulses the priority is `ev_prog`, then start/resume, then done.
- R5: A read in program mode (mode 3), chip-erase mode (mode 4) or sector-erase mode (mode 5) returns the status byte with bit 6 already inverted, and leaves bit 6 inverted. Reads in other modes leave bit 6 unchanged.
- R6: A read in mode 4 or mode 5 also inverts bit 2. A read in mode 3 leaves bit 2 unchanged.
- R7: Bit 3 is cleared by `ev_erase_start`, `ev_done` or `ev_suspend`, and set by `ev_erase_begin` or `ev_resume`. A set takes priority over a clear.
- R8: In read mode (mode 0) with `erase_susp` high, a read with `addr_erasing` high returns the status byte with bit 2 inverted and bit 6 untouched. Any other mode-0 read returns `array_data`.
- R9: In ID mode (mode 1), index 0 returns `id0` and index 1 returns `id1`. Index 2 returns 0. Index 0x0E returns `id2` and index 0x0F returns `id3`, unless that ID is all ones, in which case `array_data` is returned. All other indices return `array_data`.
- R10: In query mode (mode 2), an index below `CFI_DEPTH` returns `cfi_byte` zero-extended, and any other index returns 0.
- R11: The status flags bits 6 and 2 change only in cycles with `rd_stb` high, never on idle cycles.
- R12: A read in the same cycle as an event pulse returns bit 7 and bit 3 as they were before that event. The event still takes effect for later reads.
- R13: Mode codes 6 and 7 return `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Sequencer mode: 0 read, 1 ID, 2 query, 3 program, 4 chip erase, 5 sector erase |
| rd_stb | input | 1 | Read strobe |
| word_idx | input | IDX_W | Word index within the device |
| array_data | input | DW | Array word at the read address |
| cfi_byte | input | 8 | Query table byte at `word_idx` |
| id0 | input | DW | Identification word 0 |
| id1 | input | DW | Identification word 1 |
| id2 | input | DW | Identification word 2 |
| id3 | input | DW | Identification word 3 |
| erase_susp | input | 1 | An erase is suspended |
| addr_erasing | input | 1 | The read address lies in a sector marked for erase |
| ev_prog | input | 1 | Program accepted (pulse) |
| prog_d7 | input | 1 | Bit 7 of the programmed data |
| ev_erase_start | input | 1 | Chip or sector erase command accepted (pulse) |
| ev_erase_begin | input | 1 | Sector-erase window closed, erase running (pulse) |
| ev_done | input | 1 | Program or erase complete (pulse) |
| ev_suspend | input | 1 | Erase suspended (pulse) |
| ev_resume | input | 1 | Erase resumed (pulse) |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | `rd_data` was updated this cycle |

## Verification
A read strobe and a sequencer event can land in the same cycle. The read toggles bits 6 and 2, while the event rewrites bits 7 and 3, and both must take effect. The random phase raises event pulses and read strobes independently each cycle, so such overlaps occur often. A directed case also places a program event on the cycle of a status read. The bench model applies the read with the old bit 7 and bit 3, then applies the event. Each returned word and every following read are compared against that model.

// File: rtl/flash_status_poll.sv
module flash_status_poll #(
  parameter int DW        = 16,
  parameter int IDX_W     = 8,
  parameter int CFI_DEPTH = 77
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             rd_stb,
  input  logic [IDX_W-1:0] word_idx,
  input  logic [DW-1:0]    array_data,
  input  logic [7:0]       cfi_byte,
  input  logic [DW-1:0]    id0,
  input  logic [DW-1:0]    id1,
  input  logic [DW-1:0]    id2,
  input  logic [DW-1:0]    id3,
  input  logic             erase_susp,
  input  logic             addr_erasing,
  input  logic             ev_prog,
  input  logic             prog_d7,
  input  logic             ev_erase_start,
  input  logic             ev_erase_begin,
  input  logic             ev_done,
  input  logic             ev_suspend,
  input  logic             ev_resume,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);

  localparam logic [2:0] M_READ = 3'd0;
  localparam logic [2:0] M_ID   = 3'd1;
  localparam logic [2:0] M_CFI  = 3'd2;
  localparam logic [2:0] M_PROG = 3'd3;
  localparam logic [2:0] M_CHIP = 3'd4;
  localparam logic [2:0] M_SECT = 3'd5;
  localparam int PAD = DW - 8;

  logic dq7, dq6, dq3, dq2;
  logic busy_mode, erase_mode, susp_hit;
  logic tog6, tog2, dq6_n, dq2_n;
  logic [7:0]    stat_n;
  logic [DW-1:0] sel;

  assign busy_mode  = (mode == M_PROG) || (mode == M_CHIP) || (mode == M_SECT);
  assign erase_mode = (mode == M_CHIP) || (mode == M_SECT);
  assign susp_hit   = (mode == M_READ) && erase_susp && addr_erasing;

  assign tog6  = rd_stb && busy_mode;
  assign tog2  = rd_stb && (erase_mode || susp_hit);
  assign dq6_n = dq6 ^ tog6;
  assign dq2_n = dq2 ^ tog2;
  assign stat_n = {dq7, dq6_n, 2'b00, dq3, dq2_n, 2'b00};

  always_comb begin
    sel = array_data;
    unique case (mode)
      M_READ: if (susp_hit) sel = {{PAD{1'b0}}, stat_n};
      M_ID: begin
        if (word_idx == IDX_W'(0))       sel = id0;
        else if (word_idx == IDX_W'(1))  sel = id1;
        else if (word_idx == IDX_W'(2))  sel = '0;
        else if (word_idx == IDX_W'(14)) sel = (&id2) ? array_data : id2;
        else if (word_idx == IDX_W'(15)) sel = (&id3) ? array_data : id3;
      end
      M_CFI: sel = (int'(word_idx) < CFI_DEPTH) ? {{PAD{1'b0}}, cfi_byte} : '0;
      M_PROG, M_CHIP, M_SECT: sel = {{PAD{1'b0}}, stat_n};
      default: sel = array_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq7 <= 1'b0;
      dq6 <= 1'b0;
      dq3 <= 1'b0;
      dq2 <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      dq6 <= dq6_n;
      dq2 <= dq2_n;
      if (ev_prog)                         dq7 <= ~prog_d7;
      else if (ev_erase_start || ev_resume) dq7 <= 1'b0;
      else if (ev_done)                    dq7 <= ~dq7;
      if (ev_erase_begin || ev_resume)     dq3 <= 1'b1;
      else if (ev_erase_start || ev_done || ev_suspend) dq3 <= 1'b0;
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= sel;
    end
  end

  // R2
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  // R2
  rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (!rd_valid && $stable(rd_data)));
  // R11
  idle_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(dq6) && $stable(dq2)));
  // R3
  prog_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> (dq7 == !$past(prog_d7)));
  // R6
  prog_keeps_dq2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode == M_PROG) |=> $stable(dq2));
  // R7
  erase_begin_dq3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erase_begin |=> dq3);
  // R5
  erase_read_dq6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && erase_mode) |=> (dq6 != $past(dq6)));

endmodule

// File: tb/flash_status_poll_bench.sv
module flash_status_poll_bench;
  localparam int DW = 16;
  localparam int IDX_W = 8;
  localparam int CFI_DEPTH = 77;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic rd_stb = 1'b0;
  logic [IDX_W-1:0] word_idx = '0;
  logic [DW-1:0] array_data = '0, id0 = '0, id1 = '0, id2 = '0, id3 = '0;
  logic [7:0] cfi_byte = '0;
  logic erase_susp = 1'b0, addr_erasing = 1'b0;
  logic ev_prog = 1'b0, prog_d7 = 1'b0, ev_erase_start = 1'b0, ev_erase_begin = 1'b0;
  logic ev_done = 1'b0, ev_suspend = 1'b0, ev_resume = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  int checks = 0, failures = 0, cycles = 0;
  logic m7 = 0, m6 = 0, m3 = 0, m2 = 0;
  logic [DW-1:0] m_rd = '0;

  always #10 clk = ~clk;

  flash_status_poll #(.DW(DW), .IDX_W(IDX_W), .CFI_DEPTH(CFI_DEPTH)) u_flash_status_poll (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_stb(rd_stb), .word_idx(word_idx),
    .array_data(array_data), .cfi_byte(cfi_byte), .id0(id0), .id1(id1), .id2(id2), .id3(id3),
    .erase_susp(erase_susp), .addr_erasing(addr_erasing), .ev_prog(ev_prog), .prog_d7(prog_d7),
    .ev_erase_start(ev_erase_start), .ev_erase_begin(ev_erase_begin), .ev_done(ev_done),
    .ev_suspend(ev_suspend), .ev_resume(ev_resume), .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] stat(logic b7, logic b6, logic b3, logic b2);
    return DW'({b7, b6, 2'b00, b3, b2, 2'b00});
  endfunction

  function automatic logic [DW-1:0] expect_read();
    case (mode)
      3'd0: return (erase_susp && addr_erasing) ? stat(m7, m6, m3, ~m2) : array_data;
      3'd1: begin
        if (word_idx == 0) return id0;
        if (word_idx == 1) return id1;
        if (word_idx == 2) return '0;
        if (word_idx == 14) return (id2 == '1) ? array_data : id2;
        if (word_idx == 15) return (id3 == '1) ? array_data : id3;
        return array_data;
      end
      3'd2: return (int'(word_idx) < CFI_DEPTH) ? DW'(cfi_byte) : '0;
      3'd3: return stat(m7, ~m6, m3, m2);
      3'd4, 3'd5: return stat(m7, ~m6, m3, ~m2);
      default: return array_data;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] md);
    case (md)
      3'd0: return "R8";
      3'd1: return "R9";
      3'd2: return "R10";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R13";
    endcase
  endfunction

  task automatic tick(string tag);
    logic ev;
    ev = 1'b0;
    if (rd_stb) begin
      m_rd = expect_read();
      if (mode >= 3 && mode <= 5) m6 = ~m6;
      if (mode == 4 || mode == 5 || (mode == 0 && erase_susp && addr_erasing)) m2 = ~m2;
      ev = 1'b1;
    end
    if (ev_prog) m7 = ~prog_d7;
    else if (ev_erase_start || ev_resume) m7 = 1'b0;
    else if (ev_done) m7 = ~m7;
    if (ev_erase_begin || ev_resume) m3 = 1'b1;
    else if (ev_erase_start || ev_done || ev_suspend) m3 = 1'b0;
    @(negedge clk);
    check("R2", DW'(rd_valid), DW'(ev));
    check(tag.len() != 0 ? tag : (ev ? tag_of(mode) : "R2"), rd_data, m_rd);
  endtask

  task automatic clr();
    rd_stb = 0; ev_prog = 0; ev_erase_start = 0; ev_erase_begin = 0;
    ev_done = 0; ev_suspend = 0; ev_resume = 0; erase_susp = 0; addr_erasing = 0;
  endtask

  task automatic rd(logic [2:0] md, int idx, string tag);
    clr(); mode = md; word_idx = IDX_W'(idx); rd_stb = 1; tick(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    check("R1", DW'(rd_valid), '0);
    check("R1", rd_data, '0);
    rst_n = 1;
    rd(3'd3, 0, "R1");
    array_data = 16'h1234; id0 = 16'h0001; id1 = 16'h22aa; id2 = '1; id3 = 16'h0c0c;
    cfi_byte = 8'h51;
    // R3
    clr(); ev_prog = 1; prog_d7 = 1; tick("R3");
    rd(3'd3, 0, "R3");
    clr(); ev_prog = 1; prog_d7 = 0; tick("R3");
    rd(3'd3, 0, "R3");
    // R11 idle cycles then read
    clr(); repeat (5) tick("R11");
    rd(3'd3, 0, "R11");
    // R4 / R7
    clr(); ev_erase_start = 1; tick("R4");
    rd(3'd5, 0, "R7");
    clr(); ev_erase_begin = 1; tick("R7");
    rd(3'd5, 0, "R7");
    clr(); ev_suspend = 1; tick("R7");
    clr(); mode = 0; erase_susp = 1; addr_erasing = 1; rd_stb = 1; tick("R8");
    clr(); mode = 0; erase_susp = 1; addr_erasing = 0; rd_stb = 1; tick("R8");
    clr(); ev_resume = 1; tick("R7");
    rd(3'd4, 0, "R6");
    clr(); ev_done = 1; tick("R4");
    rd(3'd4, 0, "R4");
    // R12 event and read in one cycle
    clr(); mode = 3; rd_stb = 1; ev_prog = 1; prog_d7 = 0; tick("R12");
    rd(3'd3, 0, "R12");
    clr(); mode = 5; rd_stb = 1; ev_erase_begin = 1; tick("R12");
    rd(3'd5, 0, "R12");
    // R9 / R10 / R13
    rd(3'd1, 0, "R9"); rd(3'd1, 1, "R9"); rd(3'd1, 2, "R9");
    rd(3'd1, 14, "R9"); rd(3'd1, 15, "R9"); rd(3'd1, 7, "R9");
    rd(3'd2, CFI_DEPTH - 1, "R10"); rd(3'd2, CFI_DEPTH, "R10"); rd(3'd2, 255, "R10");
    rd(3'd6, 3, "R13"); rd(3'd7, 3, "R13");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      clr();
      mode = 3'($urandom_range(0, 7));
      rd_stb = ($urandom_range(0, 2) != 0);
      word_idx = ($urandom_range(0, 1) != 0) ? IDX_W'($urandom_range(0, 16)) : IDX_W'($urandom);
      array_data = DW'($urandom); cfi_byte = 8'($urandom);
      id0 = DW'($urandom); id1 = DW'($urandom);
      id2 = ($urandom_range(0, 1) != 0) ? '1 : DW'($urandom);
      id3 = ($urandom_range(0, 1) != 0) ? '1 : DW'($urandom);
      erase_susp = 1'($urandom); addr_erasing = 1'($urandom);
      ev_prog = ($urandom_range(0, 9) == 0); prog_d7 = 1'($urandom);
      ev_erase_start = ($urandom_range(0, 9) == 0);
      ev_erase_begin = ($urandom_range(0, 9) == 0);
      ev_done = ($urandom_range(0, 9) == 0);
      ev_suspend = ($urandom_range(0, 9) == 0);
      ev_resume = ($urandom_range(0, 9) == 0);
      tick("");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule